// File: doc/BRIEF.md
# Power Island Switching Sequencer

This block turns one gated power island off and on under register control. Software programs two timing registers, one per direction, and a gating-enable bit. It then sets a request bit in a control register. The sequencer steps through two timed phases and drives two outputs: the isolation clamp enable and the power-switch enable. A busy flag stays high from the moment a request is accepted until the sequence has finished.

To turn the island off, the block raises isolation when it starts the first phase. It opens the power switch when the second phase ends. To turn the island on, it closes the switch when it starts the first phase. It releases isolation after both phases. Each phase lasts the count programmed for it, in bus-clock cycles. A count of zero is stretched to one cycle, so a sequence always ends. The register port is a plain single-cycle write strobe. The read data is combinational from the address.

Top module: `pwr_island_seq`

## Requirements
- R1: After synchronous reset the island is powered (sw_en=1), isolation is released (iso_en=0) and busy=0. Both timing registers read 0x0000_0101. The control register and the gating register read 0.
- R2: Register offsets are as follows. Control is at 0x000 (bit 0 requests power-down, bit 1 requests power-up). Gating enable is at 0x260 (bit 0). Power-up timing is at 0x264 and power-down timing is at 0x268. A timing register keeps the first-phase count in bits [5:0] and the second-phase count in bits [13:8]. All other bits read as zero.
- R3: A power-down request is accepted by a write at clock edge E0 while gating is enabled. From E0+1 on, iso_en is 1. The switch opens (sw_en falls) at edge E0+1+L1+L2. Here L1 is the first-phase count and L2 the second-phase count, each taken from the power-down timing register.
- R4: A power-up request accepted at edge E0 sets sw_en=1 from E0+1 on. It clears iso_en at edge E0+1+L1+L2, with L1 and L2 taken from the power-up timing register.
- R5: The length of a phase is its count in cycles, and a count of 0 gives a one-cycle phase. A sequence with both counts at zero therefore keeps busy high for 3 cycles.
- R6: busy is high from the edge that accepts a request until the edge that ends the sequence. At that edge the request bit clears itself, and the control register then reads 0.
- R7: A write to the control register while busy is high is ignored. It sets no request bit and starts no later sequence.
- R8: If both request bits are written at once, power-down is carried out and the power-up request is discarded when that sequence ends.
- R9: If gating enable is 0 when a power-down request is serviced, the request clears one cycle after it is accepted and neither sw_en nor iso_en changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all phases are counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| iso_en | output | 1 | Isolation clamp enable for the island |
| sw_en | output | 1 | Power-switch enable (1 = island powered) |
| busy | output | 1 | A request is pending or a sequence is running |

## Verification
A phase counter that is off by one moves the edge of sw_en or iso_en, and it shortens or lengthens the busy pulse. The bench measures both cycle by cycle against 1+L1+L2, so such an error shows within the first sequence that uses the faulty count. A request bit that is left set restarts a sequence, or shows up in the control read-back as soon as busy falls. An ordering fault between isolation and the switch leaves the island unclamped while it is off, and that shows in the very cycle the switch opens.

// File: rtl/pis_pkg.sv
package pis_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_GATE   = 12'h260;
    localparam logic [ADDR_W-1:0] OFF_UP_DLY = 12'h264;
    localparam logic [ADDR_W-1:0] OFF_DN_DLY = 12'h268;

    localparam int CTRL_DN_BIT = 0;
    localparam int CTRL_UP_BIT = 1;
    localparam int SECOND_LSB  = 8;

    typedef struct packed {
        logic [CNT_W-1:0] second;
        logic [CNT_W-1:0] first;
    } dly_t;

    localparam dly_t DLY_RESET = '{second: 6'd1, first: 6'd1};

    typedef struct packed {
        logic gate_en;
        dly_t up_dly;
        dly_t dn_dly;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DN_A = 3'd1,
        ST_DN_B = 3'd2,
        ST_UP_A = 3'd3,
        ST_UP_B = 3'd4
    } seq_st_t;

    function automatic logic [DATA_W-1:0] dly_to_word(dly_t d);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_W-1:0] = d.first;
        w[SECOND_LSB +: CNT_W] = d.second;
        return w;
    endfunction

    function automatic dly_t word_to_dly(logic [DATA_W-1:0] w);
        dly_t d;
        d.first  = w[CNT_W-1:0];
        d.second = w[SECOND_LSB +: CNT_W];
        return d;
    endfunction

    function automatic logic [CNT_W-1:0] load_value(logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

endpackage

// File: rtl/pis_regs.sv
module pis_regs
    import pis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              clr_dn,
    input  logic              clr_up,
    output logic              pend_dn,
    output logic              pend_up,
    output cfg_t              cfg
);

    logic wr_ctrl;
    assign wr_ctrl = wr_en && (addr == OFF_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_dn     <= 1'b0;
            pend_up     <= 1'b0;
            cfg.gate_en <= 1'b0;
            cfg.up_dly  <= DLY_RESET;
            cfg.dn_dly  <= DLY_RESET;
        end else begin
            if (wr_ctrl && !busy) begin
                pend_dn <= wdata[CTRL_DN_BIT];
                pend_up <= wdata[CTRL_UP_BIT];
            end else begin
                if (clr_dn) pend_dn <= 1'b0;
                if (clr_up) pend_up <= 1'b0;
            end
            if (wr_en && addr == OFF_GATE)   cfg.gate_en <= wdata[0];
            if (wr_en && addr == OFF_UP_DLY) cfg.up_dly  <= word_to_dly(wdata);
            if (wr_en && addr == OFF_DN_DLY) cfg.dn_dly  <= word_to_dly(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: begin
                rdata[CTRL_DN_BIT] = pend_dn;
                rdata[CTRL_UP_BIT] = pend_up;
            end
            OFF_GATE:   rdata[0] = cfg.gate_en;
            OFF_UP_DLY: rdata = dly_to_word(cfg.up_dly);
            OFF_DN_DLY: rdata = dly_to_word(cfg.dn_dly);
            default:    rdata = '0;
        endcase
    end

    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_ctrl) |=> (!$rose(pend_dn) && !$rose(pend_up)))
        else $error("request accepted while busy");

endmodule

// File: rtl/pis_phase_timer.sv
module pis_phase_timer
    import pis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_value(count);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

    assert_zero_len_R5: assert property (@(posedge clk) disable iff (rst)
        (load && count == '0) |=> expire)
        else $error("zero count phase longer than one cycle");

endmodule

// File: rtl/pis_seq_fsm.sv
module pis_seq_fsm
    import pis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pend_dn,
    input  logic             pend_up,
    input  cfg_t             cfg,
    input  logic             expire,
    output logic             load,
    output logic [CNT_W-1:0] load_cnt,
    output logic             clr_dn,
    output logic             clr_up,
    output logic             active,
    output logic             iso_q,
    output logic             sw_q
);

    seq_st_t state_q, state_d;
    logic    iso_d, sw_d;

    always_comb begin
        state_d  = state_q;
        iso_d    = iso_q;
        sw_d     = sw_q;
        load     = 1'b0;
        load_cnt = '0;
        clr_dn   = 1'b0;
        clr_up   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_dn) begin
                    if (cfg.gate_en) begin
                        state_d  = ST_DN_A;
                        iso_d    = 1'b1;
                        load     = 1'b1;
                        load_cnt = cfg.dn_dly.first;
                    end else begin
                        clr_dn = 1'b1;
                        clr_up = 1'b1;
                    end
                end else if (pend_up) begin
                    state_d  = ST_UP_A;
                    sw_d     = 1'b1;
                    load     = 1'b1;
                    load_cnt = cfg.up_dly.first;
                end
            end
            ST_DN_A: if (expire) begin
                state_d  = ST_DN_B;
                load     = 1'b1;
                load_cnt = cfg.dn_dly.second;
            end
            ST_DN_B: if (expire) begin
                state_d = ST_IDLE;
                sw_d    = 1'b0;
                clr_dn  = 1'b1;
                clr_up  = 1'b1;
            end
            ST_UP_A: if (expire) begin
                state_d  = ST_UP_B;
                load     = 1'b1;
                load_cnt = cfg.up_dly.second;
            end
            ST_UP_B: if (expire) begin
                state_d = ST_IDLE;
                iso_d   = 1'b0;
                clr_up  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iso_q   <= 1'b0;
            sw_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            iso_q   <= iso_d;
            sw_q    <= sw_d;
        end
    end

    assign active = (state_q != ST_IDLE);

    assert_iso_guard_R3: assert property (@(posedge clk) disable iff (rst)
        !sw_q |-> iso_q)
        else $error("switch open without isolation");

    assert_iso_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_q) |-> (sw_q && $past(state_q) == ST_UP_B))
        else $error("isolation released outside power-up end");

    assert_dn_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && pend_dn && pend_up) |=> (state_q != ST_UP_A))
        else $error("power-up taken over power-down");

endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
    import pis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              iso_en,
    output logic              sw_en,
    output logic              busy
);

    cfg_t             cfg;
    logic             pend_dn, pend_up;
    logic             clr_dn, clr_up;
    logic             load, expire, active;
    logic [CNT_W-1:0] load_cnt;

    assign busy = active | pend_dn | pend_up;

    pis_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .busy    (busy),
        .clr_dn  (clr_dn),
        .clr_up  (clr_up),
        .pend_dn (pend_dn),
        .pend_up (pend_up),
        .cfg     (cfg)
    );

    pis_phase_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .count  (load_cnt),
        .expire (expire)
    );

    pis_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pend_dn  (pend_dn),
        .pend_up  (pend_up),
        .cfg      (cfg),
        .expire   (expire),
        .load     (load),
        .load_cnt (load_cnt),
        .clr_dn   (clr_dn),
        .clr_up   (clr_up),
        .active   (active),
        .iso_q    (iso_en),
        .sw_q     (sw_en)
    );

    assert_cut_ends_seq_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_en) |-> !busy)
        else $error("busy still high after switch opened");

    assert_self_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (!pend_dn && !pend_up))
        else $error("request bit left set after sequence");

endmodule

// File: tb/pwr_island_seq_test.sv
`timescale 1ns/1ps
module pwr_island_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        iso_en, sw_en, busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pwr_island_seq uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .iso_en    (iso_en),
        .sw_en     (sw_en),
        .busy      (busy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic int plen(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    // Runs one sequence and compares every cycle with the R3/R4/R5/R6 timing.
    task automatic run_seq(input bit down, input int a, input int b);
        int total;
        int bad;
        int busy_len;
        logic iso0, sw0, e_iso, e_sw, e_busy;
        logic [31:0] rd;
        bus_write(down ? 12'h268 : 12'h264, (32'(b) << 8) | 32'(a));
        iso0 = iso_en; sw0 = sw_en;
        total = 1 + plen(a) + plen(b);
        bad = 0; busy_len = 0;
        bus_write(12'h000, down ? 32'h1 : 32'h2);
        for (int k = 0; k <= total + 1; k++) begin
            e_busy = (k < total);
            if (down) begin
                e_iso = (k >= 1) ? 1'b1 : iso0;
                e_sw  = (k < total) ? sw0 : 1'b0;
            end else begin
                e_sw  = (k >= 1) ? 1'b1 : sw0;
                e_iso = (k < total) ? iso0 : 1'b0;
            end
            if (busy) busy_len++;
            if (iso_en !== e_iso || sw_en !== e_sw || busy !== e_busy) bad++;
            @(negedge clk);
        end
        check(down ? "R3" : "R4", $sformatf("cycle mismatches a=%0d b=%0d", a, b), 32'(bad), 0);
        check("R5", $sformatf("busy length a=%0d b=%0d", a, b), 32'(busy_len), 32'(total));
        bus_read(12'h000, rd);
        check("R6", "request self-clear", rd, 0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int vals[5];
        vals[0] = 0; vals[1] = 1; vals[2] = 2; vals[3] = 7; vals[4] = 63;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "sw_en", 32'(sw_en), 1);
        check("R1", "iso_en", 32'(iso_en), 0);
        check("R1", "busy", 32'(busy), 0);
        bus_read(12'h264, rd); check("R1", "up timing", rd, 32'h101);
        bus_read(12'h268, rd); check("R1", "down timing", rd, 32'h101);
        bus_read(12'h000, rd); check("R1", "control", rd, 0);
        bus_read(12'h260, rd); check("R1", "gating", rd, 0);

        // R2 field masking and offsets
        bus_write(12'h264, 32'hFFFF_FFFF);
        bus_read(12'h264, rd); check("R2", "up timing mask", rd, 32'h3F3F);
        bus_write(12'h268, 32'hA5A5_1234);
        bus_read(12'h268, rd); check("R2", "down timing mask", rd, 32'h1234 & 32'h3F3F);
        bus_read(12'h264, rd); check("R2", "up timing kept", rd, 32'h3F3F);
        bus_write(12'h260, 32'hFFFF_FFFE);
        bus_read(12'h260, rd); check("R2", "gating bit0 only", rd, 0);

        // R9 gating disabled: power-down request drops with no output change
        bus_write(12'h000, 32'h1);
        check("R9", "busy first cycle", 32'(busy), 1);
        @(negedge clk);
        check("R9", "busy cleared", 32'(busy), 0);
        check("R9", "sw_en kept", 32'(sw_en), 1);
        check("R9", "iso_en kept", 32'(iso_en), 0);
        bus_read(12'h000, rd); check("R9", "request cleared", rd, 0);

        // R3 R4 R5 R6 sweep
        bus_write(12'h260, 32'h1);
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                run_seq(1'b1, vals[i], vals[j]);
                run_seq(1'b0, vals[j], vals[i]);
            end
        end

        // R7 control write while busy is ignored
        bus_write(12'h268, 32'h0505);
        bus_write(12'h000, 32'h1);
        bus_write(12'h000, 32'h2);
        repeat (20) @(negedge clk);
        check("R7", "sw_en stays off", 32'(sw_en), 0);
        check("R7", "iso_en stays on", 32'(iso_en), 1);
        check("R7", "busy idle", 32'(busy), 0);
        bus_read(12'h000, rd); check("R7", "no pending bit", rd, 0);

        // R8 both bits: power-down wins, power-up discarded
        run_seq(1'b0, 3, 2);
        bus_write(12'h268, 32'h0302);
        bus_write(12'h000, 32'h3);
        repeat (20) @(negedge clk);
        check("R8", "sw_en off", 32'(sw_en), 0);
        check("R8", "iso_en on", 32'(iso_en), 1);
        check("R8", "busy idle", 32'(busy), 0);
        bus_read(12'h000, rd); check("R8", "both bits cleared", rd, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule